// File: doc/BRIEF.md
# Identification Page Lock Controller

This block is the command handler of a serial-peripheral memory slave for one one-time lockable identification page. It takes the serial clock, chip select and serial data input as ordinary inputs that are sampled on the system clock. It shifts in an instruction byte, a 3-byte address and, for the lock command, one data byte. It answers two instructions. A status read returns a byte whose least significant bit is the lock state. A lock command makes the page read-only for good, after a modelled self-timed write.

A write-enable instruction (0x06) arms a latch, and the lock command (0x82) needs that latch. The lock command also needs address bit 10 set, data bit 1 set, and chip select rising exactly at the byte boundary that follows the eighth data bit. When the command is accepted, a busy flag covers a write cycle of a set number of system clocks, and the lock flag is set when that cycle ends. The status read (0x83) keeps sending its byte for as long as chip select stays low.

Top module: `idpage_lock_ctrl`

## Requirements
- R1: While `rst_n` and `lock_rst_n` are low, and after both are released, `busy`, `wel`, `locked` and `spi_miso_oe` are 0.
- R2: Address bit 10 is the bit sampled on the 22nd rising serial clock edge of a frame. It must be 1 for a status read to drive data and for a lock command to be accepted. The other 23 address bits have no effect.
- R3: For opcode 0x83 with bit 10 set, the byte {7'b0, locked} is sent MSB first starting after the 32nd rising edge. A new bit is presented after each rising edge, and `spi_miso_oe` is 1 while the byte is sent.
- R4: While chip select stays low after the status byte, the same byte repeats without limit.
- R5: Opcode 0x06, followed by exactly 8 rising edges and then a chip-select rise, sets `wel`. A lock command is accepted only when `wel` is 1.
- R6: Bit 1 of the lock data byte (sampled on the 39th rising edge) must be 1. The other data bits have no effect.
- R7: A lock command is accepted only if chip select rises after exactly 40 rising edges. With 39 or fewer, or 41 or more, it is discarded.
- R8: A lock command that is rejected while not busy clears `wel`.
- R9: An accepted lock sets `busy` from the next system clock for WR_CYCLES cycles. When `busy` falls, `locked` is 1 and `wel` is 0. Lock commands that arrive while busy have no effect.
- R10: `locked` never clears, including across `rst_n`. Only `lock_rst_n` clears it.
- R11: `spi_miso_oe` is 0 whenever chip select is high or no status byte is being sent. While it is 0, `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the command logic |
| lock_rst_n | input | 1 | Simulation-only reset of the lock flag |
| spi_sck | input | 1 | Serial clock, sampled on clk |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso (high-impedance when 0) |
| busy | output | 1 | Self-timed write in progress |
| wel | output | 1 | Write-enable latch |
| locked | output | 1 | Identification page locked |

## Verification
A wrong bit counter or a wrong captured qualifier shows up first on `spi_miso_oe` and `spi_miso` during a status read, within one serial bit. A fault in the accept decision shows up on `busy` one system clock after the chip-select rise. A wrong timer count moves the fall of `busy` and the rise of `locked` by whole cycles. The bench compares all five outputs against its model on every clock, so each of these faults is seen in the cycle where it first reaches a port.

// File: rtl/idlk_pkg.sv
package idlk_pkg;
  localparam int BYTE_W       = 8;
  localparam int ADDR_BYTES   = 3;
  localparam int ADDR_W       = BYTE_W * ADDR_BYTES;
  localparam int HDR_BITS     = BYTE_W * (1 + ADDR_BYTES);
  localparam int FRAME_BITS   = HDR_BITS + BYTE_W;
  localparam int CNT_MAX      = FRAME_BITS + 1;
  localparam int CNT_W        = $clog2(CNT_MAX + 1);
  localparam int QUAL_BIT     = 10;
  localparam int KEY_BIT      = 1;
  localparam int QUAL_IDX     = BYTE_W + (ADDR_W - 1 - QUAL_BIT);
  localparam int KEY_IDX      = HDR_BITS + (BYTE_W - 1 - KEY_BIT);

  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OP_LOCK = 8'h82;
  localparam logic [BYTE_W-1:0] OP_RDLK = 8'h83;

  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] op;
    logic              qual;
    logic              key;
  } frame_t;
endpackage

// File: rtl/idlk_rst_sync.sv
module idlk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/idlk_shift.sv
module idlk_shift
  import idlk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   spi_sck,
  input  logic   spi_cs_n,
  input  logic   spi_mosi,
  output frame_t frm,
  output logic   cs_rise
);
  logic              sck_q, cs_q;
  logic              sck_rise;
  logic [BYTE_W-1:0] sh_q, sh_d;
  frame_t            frm_q, frm_d;

  always_comb begin
    sck_rise = spi_sck & ~sck_q & ~spi_cs_n;
    cs_rise  = spi_cs_n & ~cs_q;
    sh_d     = sh_q;
    frm_d    = frm_q;
    if (spi_cs_n) begin
      frm_d = '0;
    end else if (sck_rise) begin
      sh_d = {sh_q[BYTE_W-2:0], spi_mosi};
      if (frm_q.cnt == CNT_W'(BYTE_W - 1)) frm_d.op   = {sh_q[BYTE_W-2:0], spi_mosi};
      if (frm_q.cnt == CNT_W'(QUAL_IDX))   frm_d.qual = spi_mosi;
      if (frm_q.cnt == CNT_W'(KEY_IDX))    frm_d.key  = spi_mosi;
      if (frm_q.op == OP_RDLK && frm_q.cnt == CNT_W'(FRAME_BITS - 1))
        frm_d.cnt = CNT_W'(HDR_BITS);
      else if (frm_q.cnt < CNT_W'(CNT_MAX))
        frm_d.cnt = frm_q.cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      sh_q  <= '0;
      frm_q <= '0;
    end else begin
      sck_q <= spi_sck;
      cs_q  <= spi_cs_n;
      sh_q  <= sh_d;
      frm_q <= frm_d;
    end
  end

  assign frm = frm_q;

  // R4
  read_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_q.op == OP_RDLK && frm_q.cnt >= CNT_W'(HDR_BITS)) |-> (frm_q.cnt < CNT_W'(FRAME_BITS)));
endmodule

// File: rtl/idlk_wcycle.sv
module idlk_wcycle
  import idlk_pkg::*;
#(
  parameter int WR_CYCLES = 1000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lock_rst_n,
  input  frame_t frm,
  input  logic   cs_rise,
  output logic   busy,
  output logic   wel,
  output logic   locked
);
  localparam int TMR_W = $clog2(WR_CYCLES + 1);

  logic             busy_q, busy_d, wel_q, wel_d, lock_q, lock_set;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             wren_ev, lock_ev, lock_ok;

  always_comb begin
    wren_ev  = cs_rise && frm.op == OP_WREN && frm.cnt == CNT_W'(BYTE_W);
    lock_ev  = cs_rise && frm.op == OP_LOCK;
    lock_ok  = frm.cnt == CNT_W'(FRAME_BITS) && frm.qual && frm.key && wel_q;
    busy_d   = busy_q;
    wel_d    = wren_ev ? 1'b1 : wel_q;
    tmr_d    = tmr_q;
    lock_set = 1'b0;
    if (busy_q) begin
      if (tmr_q == '0) begin
        busy_d   = 1'b0;
        wel_d    = 1'b0;
        lock_set = 1'b1;
      end else begin
        tmr_d = tmr_q - 1'b1;
      end
    end else if (lock_ev) begin
      if (lock_ok) begin
        busy_d = 1'b1;
        tmr_d  = TMR_W'(WR_CYCLES - 1);
      end else begin
        wel_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      tmr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      wel_q  <= wel_d;
      tmr_q  <= tmr_d;
    end
  end

  always_ff @(posedge clk or negedge lock_rst_n) begin
    if (!lock_rst_n)   lock_q <= 1'b0;
    else if (lock_set) lock_q <= 1'b1;
  end

  assign busy   = busy_q;
  assign wel    = wel_q;
  assign locked = lock_q;

  // R5
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wel_q));
  // R6
  key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(frm.key));
  // R7
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($past(frm.cnt) == CNT_W'(FRAME_BITS)));
  // R9
  cycle_end_chk: assert property (@(posedge clk) disable iff (!rst_n || !lock_rst_n)
    $fell(busy_q) |-> (lock_q && !wel_q));
  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!lock_rst_n)
    lock_q |=> lock_q);
endmodule

// File: rtl/idpage_lock_ctrl.sv
module idpage_lock_ctrl
  import idlk_pkg::*;
#(
  parameter int WR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe,
  output logic busy,
  output logic wel,
  output logic locked
);
  logic              rst_s_n, lock_rst_s_n, cs_rise, rd_active;
  logic [BYTE_W-1:0] status_byte;
  frame_t            frm;

  idlk_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_s_n));
  idlk_rst_sync #(.STAGES(2)) i_lock_rst_sync (
    .clk(clk), .arst_n(lock_rst_n), .rst_n_o(lock_rst_s_n));

  idlk_shift i_shift (
    .clk(clk), .rst_n(rst_s_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .frm(frm), .cs_rise(cs_rise));

  idlk_wcycle #(.WR_CYCLES(WR_CYCLES)) i_wcycle (
    .clk(clk), .rst_n(rst_s_n), .lock_rst_n(lock_rst_s_n), .frm(frm),
    .cs_rise(cs_rise), .busy(busy), .wel(wel), .locked(locked));

  always_comb begin
    status_byte = {{(BYTE_W-1){1'b0}}, locked};
    rd_active   = ~spi_cs_n && frm.op == OP_RDLK && frm.qual && frm.cnt >= CNT_W'(HDR_BITS);
    spi_miso_oe = rd_active;
    spi_miso    = rd_active & status_byte[~frm.cnt[2:0]];
  end
endmodule

// File: tb/test_idpage_lock_ctrl.sv
module test_idpage_lock_ctrl;
  localparam int WR = 400;

  logic clk = 1'b0;
  logic rst_n, lock_rst_n, sck, cs_n, mosi;
  logic miso, miso_oe, busy, wel, locked;
  int   n_chk = 0, n_fail = 0;
  bit   cmp_en = 0;

  idpage_lock_ctrl #(.WR_CYCLES(WR)) i_idpage_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .lock_rst_n(lock_rst_n), .spi_sck(sck),
    .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
    .busy(busy), .wel(wel), .locked(locked));

  always #4 clk = ~clk;

  // behavioural reference model
  int m_bits, m_op, m_qual, m_key, m_wel, m_busy, m_tmr, m_locked, m_sh, m_sckq, m_csq;
  initial begin
    m_bits = 0; m_op = 0; m_qual = 0; m_key = 0; m_wel = 0; m_busy = 0;
    m_tmr = 0; m_locked = 0; m_sh = 0; m_sckq = 0; m_csq = 1;
  end

  always @(posedge clk) begin
    bit rise, csr;
    if (!lock_rst_n) m_locked = 0;
    if (!rst_n) begin
      m_bits = 0; m_op = 0; m_qual = 0; m_key = 0; m_wel = 0; m_busy = 0;
      m_tmr = 0; m_sh = 0; m_sckq = 0; m_csq = 1;
    end else begin
      rise = sck && !m_sckq && !cs_n;
      csr  = cs_n && !m_csq;
      if (csr && m_op == 8'h06 && m_bits == 8) m_wel = 1;
      if (m_busy != 0) begin
        if (m_tmr == 0) begin m_busy = 0; m_wel = 0; m_locked = 1; end
        else m_tmr--;
      end else if (csr && m_op == 8'h82) begin
        if (m_bits == 40 && m_qual != 0 && m_key != 0 && m_wel != 0) begin
          m_busy = 1; m_tmr = WR - 1;
        end else m_wel = 0;
      end
      if (cs_n) begin
        m_bits = 0; m_op = 0; m_qual = 0; m_key = 0;
      end else if (rise) begin
        m_sh = ((m_sh << 1) | int'(mosi)) & 255;
        if (m_bits == 7)  m_op = m_sh;
        if (m_bits == 21) m_qual = int'(mosi);
        if (m_bits == 38) m_key = int'(mosi);
        if (m_op == 8'h83 && m_bits == 39) m_bits = 32;
        else if (m_bits < 41) m_bits++;
      end
      m_sckq = int'(sck);
      m_csq  = int'(cs_n);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      int e_oe, e_miso;
      e_oe   = (!cs_n && m_op == 8'h83 && m_qual != 0 && m_bits >= 32) ? 1 : 0;
      e_miso = (e_oe != 0 && m_locked != 0 && (m_bits % 8) == 7) ? 1 : 0;
      check("R11 oe model", int'(miso_oe), e_oe);
      check("R3 miso model", int'(miso), e_miso);
      check("R9 busy model", int'(busy), m_busy);
      check("R10 locked model", int'(locked), m_locked);
      check("R5 wel model", int'(wel), m_wel);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    #1 sck = 1'b0; mosi = b;
    wait_cyc(2);
    #1 sck = 1'b1;
    wait_cyc(2);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic cs_low();
    #1 cs_n = 1'b0;
    wait_cyc(2);
  endtask

  task automatic cs_high();
    #1 cs_n = 1'b1; sck = 1'b0;
    wait_cyc(3);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic q);
    logic [23:0] a;
    a = (24'hA5F3C9 & ~24'h000400) | (24'(q) << 10);
    send_byte(op);
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
  endtask

  task automatic read_byte(output logic [7:0] v, output int oe_all);
    v = '0; oe_all = 1;
    for (int i = 0; i < 8; i++) begin
      #1 sck = 1'b0; mosi = 1'b0;
      @(negedge clk);
      v = {v[6:0], miso};
      if (!miso_oe) oe_all = 0;
      @(negedge clk);
      #1 sck = 1'b1;
      wait_cyc(2);
    end
  endtask

  task automatic do_wren();
    cs_low(); send_byte(8'h06); cs_high();
  endtask

  task automatic do_lock(input logic q, input logic [7:0] d, input int nbits);
    cs_low(); send_hdr(8'h82, q);
    for (int i = 0; i < nbits; i++) send_bit(d[7 - (i % 8)]);
    cs_high();
  endtask

  task automatic status_read(input string tag, input int nbytes, input int exp);
    logic [7:0] v;
    int oe;
    cs_low(); send_hdr(8'h83, 1'b1);
    for (int k = 0; k < nbytes; k++) begin
      read_byte(v, oe);
      check(tag, int'(v), exp);
      check({tag, " oe"}, oe, 1);
    end
    cs_high();
    check("R11 oe after cs high", int'(miso_oe), 0);
  endtask

  initial begin
    logic [7:0] v;
    int oe;
    rst_n = 1'b0; lock_rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    wait_cyc(3);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset wel", int'(wel), 0);
    check("R1 reset locked", int'(locked), 0);
    #1 rst_n = 1'b1; lock_rst_n = 1'b1;
    wait_cyc(5);
    check("R1 released oe", int'(miso_oe), 0);
    check("R1 released locked", int'(locked), 0);
    cmp_en = 1;

    // R3 R4: unlocked status byte repeats as 0x00
    status_read("R4 unlocked status", 2, 0);

    // R2: address bit 10 clear gives no read data
    cs_low(); send_hdr(8'h83, 1'b0); read_byte(v, oe);
    check("R2 no oe without bit10", oe, 0);
    cs_high();

    // R5: lock without write enable
    do_lock(1'b1, 8'h02, 8);
    check("R5 no wel lock busy", int'(busy), 0);
    wait_cyc(3);
    check("R5 no wel not locked", int'(locked), 0);

    // R5 write enable sets latch
    do_wren();
    check("R5 wel set", int'(wel), 1);

    // R6 R8: bit1 clear rejected, latch cleared
    do_lock(1'b1, 8'hFD, 8);
    check("R6 key clear busy", int'(busy), 0);
    check("R8 wel cleared", int'(wel), 0);

    // R7: 9 and 7 data bits rejected
    do_wren();
    do_lock(1'b1, 8'h02, 9);
    check("R7 late cs busy", int'(busy), 0);
    check("R8 late cs wel", int'(wel), 0);
    do_wren();
    do_lock(1'b1, 8'h02, 7);
    check("R7 early cs busy", int'(busy), 0);

    // R2: bit10 clear rejects lock
    do_wren();
    do_lock(1'b0, 8'h02, 8);
    check("R2 bit10 clear busy", int'(busy), 0);
    check("R2 bit10 clear wel", int'(wel), 0);

    // R9: valid lock, other data bits arbitrary (R6)
    do_wren();
    do_lock(1'b1, 8'hAB, 8);
    check("R9 busy after accept", int'(busy), 1);
    check("R9 not yet locked", int'(locked), 0);
    do_wren();
    do_lock(1'b1, 8'h02, 8);
    check("R9 still busy", int'(busy), 1);
    check("R9 locked during busy", int'(locked), 0);
    wait_cyc(WR);
    check("R9 busy ended", int'(busy), 0);
    check("R9 locked set", int'(locked), 1);
    check("R9 wel cleared", int'(wel), 0);

    // R3 R4: locked status 0x01 repeated
    status_read("R3 locked status", 3, 1);

    // R10: sticky through rst_n
    cmp_en = 0;
    #1 rst_n = 1'b0;
    wait_cyc(2);
    #1 rst_n = 1'b1;
    wait_cyc(5);
    cmp_en = 1;
    check("R10 locked after rst_n", int'(locked), 1);
    check("R1 wel after rst_n", int'(wel), 0);
    #1 lock_rst_n = 1'b0;
    wait_cyc(2);
    #1 lock_rst_n = 1'b1;
    wait_cyc(5);
    check("R10 lock_rst_n clears", int'(locked), 0);
    status_read("R3 cleared status", 1, 0);

    summary();
  end
endmodule